// File: doc/BRIEF.md
# Strobed Row/Column DRAM Access Controller

This block connects a simple host request port to a dynamic memory device whose row and column addresses share one set of address pins. The host presents a flat word address, a write flag and a data byte, and waits for `ready_o` before raising a request. The controller keeps the upper address bits as the row and the lower bits as the column. It places the row on the shared bus and drops the active-low row strobe. While the row strobe stays low it switches the bus to the column and drops the active-low column strobe. A read returns one byte from the selected row together with a single-cycle `done_o`. A write drives the byte onto the device data lines with the device write enable low.

An internal timer asks for a refresh at a fixed interval. Between host accesses the controller runs a row-strobe-only cycle on the next row in turn. Strobing the row makes the device read that row out and write it back. Refresh rows advance in ascending order and wrap after the last row. A pending refresh wins over a waiting host request. It never breaks into an access that has already started.

Top module: `dram_ctrl`

## Requirements
- R1: After reset, `ras_no` and `cas_no` are high, `dram_we_no` is high, `done_o` is low and `ready_o` is high.
- R2: The flat address splits as row = `addr_i[ROW_W+COL_W-1:COL_W]` and column = `addr_i[COL_W-1:0]`. The row is on `dram_addr_o` when `ras_no` falls. The column is on `dram_addr_o` when `cas_no` falls later in the same row-strobe period.
- R3: A read returns the byte stored at the addressed row and column on `rdata_o`. `done_o` is high in the 5th cycle after the clock edge that accepts the request.
- R4: A write stores `wdata_i` at the addressed row and column, with `dram_we_no` low while `cas_no` is low. Other columns of the same row keep their contents.
- R5: A request is accepted only on an edge where `req_i` and `ready_o` are both high. While an access is in progress, `ready_o` is low and a held `req_i` starts no second column strobe. `done_o` is high for exactly one cycle per access.
- R6: With no host traffic, a refresh starts every `REFRESH_INTERVAL` clocks. It holds `ras_no` low for 2 cycles and leaves `cas_no` high throughout.
- R7: Successive refreshes address rows 0, 1, 2, … in ascending order. After row `2**ROW_W-1` the next refresh addresses row 0.
- R8: A pending refresh is served before a waiting host request, so a host that requests without pause cannot starve refresh. Each row-strobe period of a host access contains exactly one column strobe and no refresh.
- R9: `cas_no` and `dram_we_no` are low only while `ras_no` is low. Both strobes are high whenever the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| we_i | input | 1 | Host write flag (1 = write) |
| addr_i | input | ROW_W+COL_W | Flat host word address |
| wdata_i | input | DATA_W | Host write byte |
| ready_o | output | 1 | Controller can accept a request this cycle |
| done_o | output | 1 | One-cycle access completion pulse |
| rdata_o | output | DATA_W | Read data, valid with done_o on reads |
| dram_addr_o | output | max(ROW_W,COL_W) | Shared row/column address bus |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Device write enable, active low |
| dram_dq_o | output | DATA_W | Data driven to the device on writes |
| dram_dq_i | input | DATA_W | Data returned by the device while cas_no is low |

## Verification
The bench builds the controller with an 8-row by 4-column array and a refresh interval of 24 clocks. It attaches a behavioural array model that latches the row and column on the strobe edges. The tiny array lets a few accesses reach the last row and the last column. The short interval lets about ten idle refreshes run the row counter through its wrap from 7 to 0 within a few hundred cycles. It also forces refresh requests to collide with a continuous stream of host requests.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_ROW,
    S_RAS,
    S_COL,
    S_CAS,
    S_DONE,
    S_RF_ROW,
    S_RF_RAS,
    S_RF_HOLD
  } seq_state_e;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int INTERVAL = 780,
  parameter int ROW_W    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // new tick wins over a same-cycle ack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
    end else if (tick) begin
      pend_o <= 1'b1;
    end else if (ack_i) begin
      pend_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o <= '0;
    end else if (ack_i) begin
      row_o <= row_o + 1'b1;
    end
  end

  // R6
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !ack_i) |=> pend_o);

  // R7
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (row_o == ROW_W'($past(row_o) + 1'b1)));
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int ROW_W = 12,
  parameter int COL_W = 9,
  parameter int BUS_W = 12
) (
  input  logic [ROW_W-1:0] host_row_i,
  input  logic [COL_W-1:0] host_col_i,
  input  logic [ROW_W-1:0] ref_row_i,
  input  logic             sel_col_i,
  input  logic             sel_ref_i,
  output logic [BUS_W-1:0] bus_o
);
  logic [BUS_W-1:0] row_ext, col_ext, ref_ext;

  generate
    if (BUS_W > ROW_W) begin : g_row_pad
      assign row_ext = {{(BUS_W-ROW_W){1'b0}}, host_row_i};
      assign ref_ext = {{(BUS_W-ROW_W){1'b0}}, ref_row_i};
    end else begin : g_row_fit
      assign row_ext = host_row_i;
      assign ref_ext = ref_row_i;
    end
    if (BUS_W > COL_W) begin : g_col_pad
      assign col_ext = {{(BUS_W-COL_W){1'b0}}, host_col_i};
    end else begin : g_col_fit
      assign col_ext = host_col_i;
    end
  endgenerate

  always_comb begin
    if (sel_ref_i)      bus_o = ref_ext;
    else if (sel_col_i) bus_o = col_ext;
    else                bus_o = row_ext;
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int DATA_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic                   ref_pend_i,
  input  logic [ROW_W-1:0]       ref_row_i,
  output logic                   ref_ack_o,
  output logic                   ready_o,
  output logic                   done_o,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   ras_no,
  output logic                   cas_no,
  output logic                   we_no,
  output logic [DATA_W-1:0]      dq_o,
  input  logic [DATA_W-1:0]      dq_i,
  output logic                   sel_col_o,
  output logic                   sel_ref_o,
  output logic [ROW_W-1:0]       row_o,
  output logic [COL_W-1:0]       col_o,
  output logic [ROW_W-1:0]       ref_row_o
);
  localparam int ADDR_W = ROW_W + COL_W;

  seq_state_e          state_q, state_d;
  logic [ADDR_W-1:0]   addr_q;
  logic                we_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [DATA_W-1:0]   rdata_q;
  logic [ROW_W-1:0]    ref_row_q;
  logic                accept;

  assign ref_ack_o = (state_q == S_IDLE) && ref_pend_i;
  assign ready_o   = (state_q == S_IDLE) && !ref_pend_i;
  assign accept    = ready_o && req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (ref_pend_i) state_d = S_RF_ROW;
                 else if (req_i) state_d = S_ROW;
      S_ROW:     state_d = S_RAS;
      S_RAS:     state_d = S_COL;
      S_COL:     state_d = S_CAS;
      S_CAS:     state_d = S_DONE;
      S_DONE:    state_d = S_IDLE;
      S_RF_ROW:  state_d = S_RF_RAS;
      S_RF_RAS:  state_d = S_RF_HOLD;
      S_RF_HOLD: state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= addr_i;
      we_q    <= we_i;
      wdata_q <= wdata_i;
    end
  end

  // row is frozen before the timer steps its pointer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ref_row_q <= '0;
    else if (ref_ack_o) ref_row_q <= ref_row_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         rdata_q <= '0;
    else if (state_q == S_CAS && !we_q)  rdata_q <= dq_i;
  end

  assign ras_no    = !(state_q inside {S_RAS, S_COL, S_CAS, S_RF_RAS, S_RF_HOLD});
  assign cas_no    = !(state_q == S_CAS);
  assign we_no     = !(we_q && (state_q inside {S_COL, S_CAS}));
  assign sel_col_o = state_q inside {S_COL, S_CAS};
  assign sel_ref_o = state_q inside {S_RF_ROW, S_RF_RAS, S_RF_HOLD};
  assign done_o    = (state_q == S_DONE);
  assign rdata_o   = rdata_q;
  assign dq_o      = wdata_q;
  assign row_o     = addr_q[ADDR_W-1:COL_W];
  assign col_o     = addr_q[COL_W-1:0];
  assign ref_row_o = ref_row_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);

  // R8
  ras_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_no && cas_no && !sel_ref_o) |=> !ras_no);

  // R9
  cas_in_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |-> !ras_no);

  // R4
  we_in_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> !ras_no);
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter int ROW_W            = 12,
  parameter int COL_W            = 9,
  parameter int DATA_W           = 8,
  parameter int REFRESH_INTERVAL = 780,
  localparam int ADDR_W          = ROW_W + COL_W,
  localparam int BUS_W           = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [BUS_W-1:0]  dram_addr_o,
  output logic              ras_no,
  output logic              cas_no,
  output logic              dram_we_no,
  output logic [DATA_W-1:0] dram_dq_o,
  input  logic [DATA_W-1:0] dram_dq_i
);
  logic             ref_pend, ref_ack;
  logic [ROW_W-1:0] ref_row, ref_row_hold, host_row;
  logic [COL_W-1:0] host_col;
  logic             sel_col, sel_ref;

  dram_refresh_timer #(
    .INTERVAL(REFRESH_INTERVAL),
    .ROW_W   (ROW_W)
  ) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ack_i (ref_ack),
    .pend_o(ref_pend),
    .row_o (ref_row)
  );

  dram_seq #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .DATA_W(DATA_W)
  ) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .ref_pend_i(ref_pend),
    .ref_row_i (ref_row),
    .ref_ack_o (ref_ack),
    .ready_o   (ready_o),
    .done_o    (done_o),
    .rdata_o   (rdata_o),
    .ras_no    (ras_no),
    .cas_no    (cas_no),
    .we_no     (dram_we_no),
    .dq_o      (dram_dq_o),
    .dq_i      (dram_dq_i),
    .sel_col_o (sel_col),
    .sel_ref_o (sel_ref),
    .row_o     (host_row),
    .col_o     (host_col),
    .ref_row_o (ref_row_hold)
  );

  dram_addr_mux #(
    .ROW_W(ROW_W),
    .COL_W(COL_W),
    .BUS_W(BUS_W)
  ) i_mux (
    .host_row_i(host_row),
    .host_col_i(host_col),
    .ref_row_i (ref_row_hold),
    .sel_col_i (sel_col),
    .sel_ref_i (sel_ref),
    .bus_o     (dram_addr_o)
  );
endmodule

// File: tb/test_dram_ctrl.sv
`timescale 1ns/1ps
module test_dram_ctrl;
  localparam int ROW_W = 3;
  localparam int COL_W = 2;
  localparam int DW    = 8;
  localparam int RI    = 24;
  localparam int AW    = ROW_W + COL_W;
  localparam int BW    = 3;
  localparam int NROW  = 1 << ROW_W;
  localparam int NV    = 13;
  // {we, addr[4:0], data[7:0]}; for reads data is the expected byte
  localparam logic [13:0] VECS [NV] = '{
    14'h20A5, 14'h3F3C, 14'h2377, 14'h3C81, 14'h250F,
    14'h00A5, 14'h1F3C, 14'h0377, 14'h205A, 14'h005A,
    14'h1C81, 14'h050F, 14'h0400
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready_o, done_o, ras_no, cas_no, dram_we_no;
  logic [DW-1:0] rdata_o, dq_o, dq_i;
  logic [BW-1:0] dram_addr_o;

  always #10 clk = ~clk;

  dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .REFRESH_INTERVAL(RI)) i_dram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready_o), .done_o(done_o), .rdata_o(rdata_o), .dram_addr_o(dram_addr_o),
    .ras_no(ras_no), .cas_no(cas_no), .dram_we_no(dram_we_no), .dram_dq_o(dq_o),
    .dram_dq_i(dq_i)
  );

  // behavioural device
  logic [DW-1:0] mem [NROW*(1<<COL_W)];
  logic [ROW_W-1:0] dev_row;
  logic dev_ras_q;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NROW*(1<<COL_W); i++) mem[i] <= '0;
      dev_row <= '0; dev_ras_q <= 1'b1;
    end else begin
      if (!ras_no && dev_ras_q) dev_row <= dram_addr_o[ROW_W-1:0];
      if (!cas_no && !dram_we_no) mem[{dev_row, dram_addr_o[COL_W-1:0]}] <= dq_o;
      dev_ras_q <= ras_no;
    end
  end
  assign dq_i = !cas_no ? mem[{dev_row, dram_addr_o[COL_W-1:0]}] : '0;

  int cyc = 0;
  always @(posedge clk) cyc++;

  // strobe monitor
  int ev_n = 0, cas_total = 0, multi_cas = 0;
  int ev_row [128], ev_t [128], ev_len [128];
  int r_row, r_t, r_len, r_cas, last_row, last_col;
  logic m_ras_q = 1'b1, m_cas_q = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ras_no && m_ras_q) begin
        r_row = int'(dram_addr_o); r_t = cyc; r_len = 0; r_cas = 0;
      end
      if (!ras_no) r_len++;
      if (!cas_no && m_cas_q) begin
        r_cas++; cas_total++; last_col = int'(dram_addr_o); last_row = r_row;
      end
      if (ras_no && !m_ras_q) begin
        if (r_cas == 0) begin
          if (ev_n < 128) begin ev_row[ev_n] = r_row; ev_t[ev_n] = r_t; ev_len[ev_n] = r_len; end
          ev_n++;
        end else if (r_cas != 1) multi_cas++;
      end
    end
    m_ras_q = ras_no; m_cas_q = cas_no;
  end

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int lat, output logic [DW-1:0] rd, output int casn, output bit pulse1);
    int c0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    for (int k = 0; k < 200 && !ready_o; k++) @(negedge clk);
    c0 = cas_total;
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    for (int k = 0; k < 50 && !done_o; k++) begin @(negedge clk); lat++; end
    rd = rdata_o;
    casn = cas_total - c0;
    @(negedge clk);
    pulse1 = !done_o;
  endtask

  initial begin
    int lat, casn, base, dones, ref0, c0;
    logic [DW-1:0] rd;
    bit p1, wrap, ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras_no && cas_no && dram_we_no && !done_o, "R1 strobes in reset", {ras_no, cas_no, dram_we_no, done_o}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready_o == 1'b1, "R1 ready after reset", ready_o, 1);

    for (int v = 0; v < NV; v++) begin
      logic vw; logic [AW-1:0] va; logic [DW-1:0] vd;
      {vw, va, vd} = VECS[v];
      access(vw, va, vd, lat, rd, casn, p1);
      chk(last_row == int'(va[AW-1:COL_W]), "R2 row on bus at ras fall", last_row, int'(va[AW-1:COL_W]));
      chk(last_col == int'(va[COL_W-1:0]), "R2 col on bus at cas fall", last_col, int'(va[COL_W-1:0]));
      chk(lat == 5, "R3 done latency", lat, 5);
      chk(casn == 1, "R5 one column strobe per access", casn, 1);
      chk(p1, "R5 done single cycle", int'(p1), 1);
      if (vw) chk(mem[va] == vd, "R4 byte written to device", int'(mem[va]), int'(vd));
      else    chk(rd == vd, "R3 read data", int'(rd), int'(vd));
    end
    // R4 neighbour column in row 1 untouched by write to address 5
    chk(mem[4] == 8'h00 && mem[6] == 8'h00, "R4 neighbours unchanged", int'(mem[6]), 0);

    // R5 request held during busy period starts nothing extra
    @(negedge clk);
    for (int k = 0; k < 200 && !ready_o; k++) @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 5'h1F;
    c0 = cas_total;
    @(negedge clk);
    ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      if (ready_o) ok = 1'b0;
      @(negedge clk);
    end
    req = 1'b0;
    chk(ok, "R5 ready low while busy", int'(ok), 1);
    chk(done_o == 1'b1, "R5 done after held request", done_o, 1);
    @(negedge clk);
    chk(cas_total - c0 == 1, "R5 held request no second strobe", cas_total - c0, 1);

    // R6, R7 idle refresh cadence and row order
    repeat (10) @(negedge clk);
    base = ev_n;
    repeat (10 * RI + 5) @(negedge clk);
    chk(ev_n - base >= 10, "R6 idle refresh count", ev_n - base, 10);
    wrap = 1'b0;
    for (int e = base + 1; e < ev_n && e < 128; e++) begin
      chk(ev_t[e] - ev_t[e-1] == RI, "R6 refresh spacing", ev_t[e] - ev_t[e-1], RI);
      chk(ev_len[e] == 2, "R6 refresh ras width", ev_len[e], 2);
      chk(ev_row[e] == (ev_row[e-1] + 1) % NROW, "R7 refresh row order", ev_row[e], (ev_row[e-1] + 1) % NROW);
      if (ev_row[e-1] == NROW - 1 && ev_row[e] == 0) wrap = 1'b1;
    end
    chk(wrap, "R7 refresh row wraps to 0", int'(wrap), 1);

    // R8 continuous host stream cannot starve refresh
    ref0 = ev_n; dones = 0;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 5'h03;
    for (int k = 0; k < 10 * RI; k++) begin
      @(negedge clk);
      if (done_o) dones++;
    end
    req = 1'b0;
    repeat (8) @(negedge clk);
    chk(ev_n - ref0 >= 9, "R8 refresh served under load", ev_n - ref0, 9);
    chk(dones >= 30, "R8 host accesses proceed", dones, 30);
    chk(multi_cas == 0, "R8 no refresh inside access", multi_cas, 0);
    chk(rdata_o == 8'h77, "R3 read data after stream", int'(rdata_o), 8'h77);

    // R9 idle strobes high
    chk(ras_no && cas_no && dram_we_no, "R9 strobes high when idle", {ras_no, cas_no, dram_we_no}, 3'b111);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule